// File: doc/BRIEF.md
# Cell-Mode UTOPIA Transmit Buffer

This block is the PHY-side transmit port of a UTOPIA Level 1 style byte interface. An ATM layer device writes 8-bit cell bytes with an active-low enable, a start-of-cell marker and a parity bit. The block assembles them into 53-byte cells in a store that holds exactly two cells. It hands only complete cells to a downstream byte consumer, which stands in for the scrambler and line encoder. The consumer pulls one byte per cycle while a cell is ready.

A single flow-control output serves both flow-control modes, selected by a mode input. In byte mode it is an active-low "full" flag that goes low only when no byte can be accepted. In cell mode it is an active-high "cell available" flag that is high only while room for one more whole cell remains. Parity is checked on every byte offered, and a sticky flag records any mismatch without disturbing the data. A start-of-cell marker that arrives partway through a cell throws away the partial cell.

Top module: `utx_cell_buffer`

## Requirements
- R1: After reset, `tx_flow` is 1 in both modes, `cell_rdy` is 0 and `par_err` is 0.
- R2: A byte presented while `tx_en_n` is 1 is not stored and changes no state, whatever `tx_soc` and `tx_data` hold.
- R3: `cell_rdy` rises in the cycle after the 53rd byte of a cell is accepted, and never while only part of a cell is stored.
- R4: Cells leave in the order they were completed, and each cell's bytes leave in write order. `cons_soc` is 1 on the first byte of each cell, and a byte is consumed on a clock edge where `cons_take` and `cell_rdy` are both 1.
- R5: The store holds at most two complete cells. Bytes offered while two complete cells are held are discarded.
- R6: With `flow_mode` = 0 (byte mode), `tx_flow` is 0 exactly while two complete cells are held, and 1 otherwise.
- R7: With `flow_mode` = 1 (cell mode), `tx_flow` is 1 exactly while the free byte count is at least 53. The free byte count is 106 − 53 × (complete cells held) − (bytes of the partial cell).
- R8: An enabled byte with `tx_soc` = 1 always starts a new cell at byte 0, and any partial cell is discarded.
- R9: An enabled byte with `tx_soc` = 0 while no cell is in progress is discarded.
- R10: Parity is odd: when the XOR of the 8 data bits and `tx_par` is 0 on an enabled byte, `par_err` goes to 1 and stays there until reset. The byte is still stored.
- R11: When a cell completes on the same edge that the last byte of another cell is consumed, the count of held cells does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit interface clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flow_mode | input | 1 | 0 = byte-mode full flag, 1 = cell-mode cell-available flag |
| tx_en_n | input | 1 | Write enable from the ATM layer, active low |
| tx_soc | input | 1 | Start-of-cell marker for the current byte |
| tx_data | input | 8 | Cell byte |
| tx_par | input | 1 | Odd parity bit for `tx_data` |
| tx_flow | output | 1 | Flow control: active-low full (byte mode) or active-high cell available (cell mode) |
| par_err | output | 1 | Sticky parity mismatch flag |
| cell_rdy | output | 1 | At least one complete cell is waiting for the consumer |
| cons_take | input | 1 | Consumer takes the presented byte on this edge |
| cons_data | output | 8 | Byte presented to the consumer |
| cons_soc | output | 1 | Presented byte is the first of its cell |

## Verification
The two functions that can land on one edge are completing a cell on the write side and releasing a cell on the read side. Both change the count of held cells, so this count drives the flow flag and the ready output. To provoke the collision, the bench writes a new cell byte by byte in lockstep with reading out an older cell, so that the 53rd write and the 53rd read share one edge. A reference model computed from the requirements predicts that the held-cell count stays at one, and the bench compares the flow flag, the ready output and every byte read out against this model. The bench runs this sequence in both flow modes, with a parity fault inside the colliding cell.

// File: rtl/utx_pkg.sv
package utx_pkg;

   typedef enum logic {
      FLOW_BYTE = 1'b0,
      FLOW_CELL = 1'b1
   } flow_mode_e;

   // width of a counter able to hold values 0..n-1, never below one bit
   function automatic int idx_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/utx_par_chk.sv
module utx_par_chk #(
   parameter int DATA_W  = 8,
   parameter bit PAR_ODD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample,
   input  logic [DATA_W-1:0] data,
   input  logic              par,
   output logic              err
);

   logic good;

   generate
      if (PAR_ODD) begin : g_odd
         assign good = ^{data, par};
      end else begin : g_even
         assign good = ~^{data, par};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         err <= 1'b0;
      else if (sample && !good)
         err <= 1'b1;
   end

   // R10: the error flag never clears once set
   assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

endmodule

// File: rtl/utx_store.sv
module utx_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 106,
   localparam int ADDR_W = (DEPTH <= 2) ? 1 : $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/utx_wr_ctrl.sv
module utx_wr_ctrl #(
   parameter int CELLS      = 2,
   parameter int CELL_BYTES = 53,
   localparam int DEPTH  = CELLS * CELL_BYTES,
   localparam int ADDR_W = (DEPTH <= 2) ? 1 : $clog2(DEPTH),
   localparam int IDX_W  = utx_pkg::idx_width(CELL_BYTES),
   localparam int SLOT_W = utx_pkg::idx_width(CELLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n,
   input  logic              soc,
   input  logic              room,
   output logic              we,
   output logic [ADDR_W-1:0] waddr,
   output logic              commit,
   output logic [IDX_W-1:0]  part_cnt
);

   logic [SLOT_W-1:0] slot_q;
   logic [IDX_W-1:0]  idx;
   logic              accept;

   assign accept = !en_n && room;
   assign idx    = soc ? '0 : part_cnt;
   assign we     = accept && (soc || (part_cnt != '0));
   assign commit = we && (idx == IDX_W'(CELL_BYTES - 1));
   assign waddr  = ADDR_W'(int'(slot_q) * CELL_BYTES + int'(idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q   <= '0;
         part_cnt <= '0;
      end else if (we) begin
         if (commit) begin
            part_cnt <= '0;
            slot_q   <= (slot_q == SLOT_W'(CELLS - 1)) ? '0 : slot_q + 1'b1;
         end else begin
            part_cnt <= idx + 1'b1;
         end
      end
   end

   // R3: a completed cell leaves no partial bytes behind
   assert_commit_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (part_cnt == '0));

   // R9: a non-start byte with no cell in progress leaves the count at zero
   assert_orphan_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_n && !soc && part_cnt == '0) |=> (part_cnt == '0));

endmodule

// File: rtl/utx_rd_ctrl.sv
module utx_rd_ctrl #(
   parameter int CELLS      = 2,
   parameter int CELL_BYTES = 53,
   localparam int DEPTH  = CELLS * CELL_BYTES,
   localparam int ADDR_W = (DEPTH <= 2) ? 1 : $clog2(DEPTH),
   localparam int IDX_W  = utx_pkg::idx_width(CELL_BYTES),
   localparam int SLOT_W = utx_pkg::idx_width(CELLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              take,
   input  logic              avail,
   output logic [ADDR_W-1:0] raddr,
   output logic              first,
   output logic              release_cell
);

   logic [SLOT_W-1:0] slot_q;
   logic [IDX_W-1:0]  idx_q;
   logic              pop;

   assign pop          = take && avail;
   assign release_cell = pop && (idx_q == IDX_W'(CELL_BYTES - 1));
   assign first        = (idx_q == '0);
   assign raddr        = ADDR_W'(int'(slot_q) * CELL_BYTES + int'(idx_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         idx_q  <= '0;
      end else if (pop) begin
         if (release_cell) begin
            idx_q  <= '0;
            slot_q <= (slot_q == SLOT_W'(CELLS - 1)) ? '0 : slot_q + 1'b1;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   // R4: reading never advances without a stored cell
   assert_hold_when_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!avail) |=> $stable(idx_q));

endmodule

// File: rtl/utx_cell_buffer.sv
module utx_cell_buffer #(
   parameter int DATA_W     = 8,
   parameter int CELLS      = 2,
   parameter int CELL_BYTES = 53,
   parameter bit PAR_ODD    = 1'b1,
   localparam int DEPTH  = CELLS * CELL_BYTES,
   localparam int ADDR_W = (DEPTH <= 2) ? 1 : $clog2(DEPTH),
   localparam int IDX_W  = utx_pkg::idx_width(CELL_BYTES),
   localparam int CNT_W  = $clog2(CELLS + 1),
   localparam int FREE_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flow_mode,
   input  logic              tx_en_n,
   input  logic              tx_soc,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_par,
   output logic              tx_flow,
   output logic              par_err,
   output logic              cell_rdy,
   input  logic              cons_take,
   output logic [DATA_W-1:0] cons_data,
   output logic              cons_soc
);

   import utx_pkg::*;

   generate
      if (CELLS < 2) begin : g_bad_cells
         $error("utx_cell_buffer: CELLS must be at least 2");
      end
      if (CELL_BYTES < 2) begin : g_bad_len
         $error("utx_cell_buffer: CELL_BYTES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("utx_cell_buffer: DATA_W must be positive");
      end
   endgenerate

   flow_mode_e        mode;
   logic [CNT_W-1:0]  held_q;
   logic              room;
   logic              we;
   logic [ADDR_W-1:0] waddr;
   logic              commit;
   logic [IDX_W-1:0]  part_cnt;
   logic [ADDR_W-1:0] raddr;
   logic              first;
   logic              release_cell;
   logic [FREE_W-1:0] free_bytes;

   assign mode     = flow_mode_e'(flow_mode);
   assign room     = (held_q != CNT_W'(CELLS));
   assign cell_rdy = (held_q != '0);
   assign cons_soc = cell_rdy && first;

   utx_par_chk #(.DATA_W(DATA_W), .PAR_ODD(PAR_ODD)) par_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .sample (!tx_en_n),
      .data   (tx_data),
      .par    (tx_par),
      .err    (par_err)
   );

   utx_wr_ctrl #(.CELLS(CELLS), .CELL_BYTES(CELL_BYTES)) wr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_n     (tx_en_n),
      .soc      (tx_soc),
      .room     (room),
      .we       (we),
      .waddr    (waddr),
      .commit   (commit),
      .part_cnt (part_cnt)
   );

   utx_rd_ctrl #(.CELLS(CELLS), .CELL_BYTES(CELL_BYTES)) rd_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .take         (cons_take),
      .avail        (cell_rdy),
      .raddr        (raddr),
      .first        (first),
      .release_cell (release_cell)
   );

   utx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
      .clk   (clk),
      .we    (we),
      .waddr (waddr),
      .wdata (tx_data),
      .raddr (raddr),
      .rdata (cons_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= '0;
      else begin
         case ({commit, release_cell})
            2'b10:   held_q <= held_q + 1'b1;
            2'b01:   held_q <= held_q - 1'b1;
            default: held_q <= held_q;
         endcase
      end
   end

   assign free_bytes = FREE_W'(DEPTH)
                     - FREE_W'(held_q) * FREE_W'(CELL_BYTES)
                     - FREE_W'(part_cnt);

   generate
      if (CELLS >= 2) begin : g_flow
         always_comb begin
            if (mode == FLOW_CELL)
               tx_flow = (free_bytes >= FREE_W'(CELL_BYTES));
            else
               tx_flow = (free_bytes != '0);
         end
      end
   endgenerate

   // R5: never more complete cells than slots
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      held_q <= CNT_W'(CELLS));

   // R5: no byte lands in the store while every slot is full
   assert_no_write_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (held_q < CNT_W'(CELLS)));

   // R4: a cell is released only when one is held
   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      release_cell |-> (held_q != '0));

   // R11: completion and release on one edge leave the count unchanged
   assert_count_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && release_cell) |=> $stable(held_q));

   // R3: a completed cell becomes visible on the next cycle
   assert_ready_after_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !release_cell) |=> cell_rdy);

endmodule

// File: tb/utx_cell_buffer_tb.sv
module utx_cell_buffer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB         = 53;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       flow_mode;
   logic       tx_en_n;
   logic       tx_soc;
   logic [7:0] tx_data;
   logic       tx_par;
   logic       tx_flow;
   logic       par_err;
   logic       cell_rdy;
   logic       cons_take;
   logic [7:0] cons_data;
   logic       cons_soc;

   always #(CLK_PERIOD / 2) clk = ~clk;

   utx_cell_buffer dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .flow_mode (flow_mode),
      .tx_en_n   (tx_en_n),
      .tx_soc    (tx_soc),
      .tx_data   (tx_data),
      .tx_par    (tx_par),
      .tx_flow   (tx_flow),
      .par_err   (par_err),
      .cell_rdy  (cell_rdy),
      .cons_take (cons_take),
      .cons_data (cons_data),
      .cons_soc  (cons_soc)
   );

   int         n_chk  = 0;
   int         n_fail = 0;
   string      phase  = "reset";
   bit         finished = 1'b0;

   // reference model
   int         m_cells;
   int         m_part;
   int         m_rcnt;
   bit         m_perr;
   logic [7:0] m_pbuf [NB];
   logic [7:0] m_q [$];

   function automatic logic [7:0] pat(input int c, input int i);
      return 8'((c * 37 + i * 11 + 5) & 255);
   endfunction

   function automatic logic exp_flow();
      if (flow_mode)
         return ((2 - m_cells) * NB - m_part) >= NB;
      return m_cells < 2;
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                      input string req, input string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s [%s] %s: actual %0h expected %0h", req, phase, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_cells = 0;
      m_part  = 0;
      m_rcnt  = 0;
      m_perr  = 1'b0;
      m_q.delete();
   endtask

   // compare outputs now, drive one cycle, then advance the model
   task automatic step(input logic en_n, input logic soc, input logic [7:0] d,
                       input logic p, input logic rd);
      bit acc;
      bit pop;
      bit rel;
      chk({7'd0, tx_flow}, {7'd0, exp_flow()}, flow_mode ? "R7" : "R6", "tx_flow");
      chk({7'd0, cell_rdy}, {7'd0, 1'(m_cells != 0)}, "R3", "cell_rdy");
      chk({7'd0, par_err}, {7'd0, m_perr}, "R10", "par_err");
      if (m_cells != 0) begin
         chk(cons_data, m_q[0], "R4", "cons_data");
         chk({7'd0, cons_soc}, {7'd0, 1'(m_rcnt == 0)}, "R4", "cons_soc");
      end
      tx_en_n   = en_n;
      tx_soc    = soc;
      tx_data   = d;
      tx_par    = p;
      cons_take = rd;
      @(negedge clk);
      acc = !en_n && (m_cells < 2);
      pop = rd && (m_cells != 0);
      rel = pop && (m_rcnt == NB - 1);
      if (!en_n && !(^{d, p})) m_perr = 1'b1;
      if (pop) begin
         void'(m_q.pop_front());
         m_rcnt = rel ? 0 : m_rcnt + 1;
      end
      if (acc) begin
         if (soc) begin
            m_pbuf[0] = d;
            m_part = 1;
         end else if (m_part != 0) begin
            m_pbuf[m_part] = d;
            m_part++;
         end
         if (m_part == NB) begin
            for (int k = 0; k < NB; k++) m_q.push_back(m_pbuf[k]);
            m_cells++;
            m_part = 0;
         end
      end
      if (rel) m_cells--;
      tx_en_n   = 1'b1;
      tx_soc    = 1'b0;
      cons_take = 1'b0;
   endtask

   task automatic wr(input int c, input int i, input bit bad, input bit rd);
      logic [7:0] d;
      d = pat(c, i);
      step(1'b0, 1'(i == 0), d, bad ? (^d) : ~(^d), rd);
   endtask

   task automatic do_reset();
      rst_n     = 1'b0;
      tx_en_n   = 1'b1;
      tx_soc    = 1'b0;
      tx_data   = '0;
      tx_par    = 1'b0;
      cons_take = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run_mode(input logic m);
      flow_mode = m;
      phase = "reset";
      do_reset();
      // R1: idle state after reset
      chk({7'd0, tx_flow}, 8'd1, "R1", "tx_flow after reset");
      chk({7'd0, cell_rdy}, 8'd0, "R1", "cell_rdy after reset");
      chk({7'd0, par_err}, 8'd0, "R1", "par_err after reset");

      // R2: disabled bytes (even with bad parity and start marker) change nothing
      phase = "R2 disabled";
      for (int i = 0; i < 6; i++) step(1'b1, 1'b1, pat(90, i), ^pat(90, i), 1'b0);

      // R9: non-start bytes with no cell in progress are discarded
      phase = "R9 orphan";
      for (int i = 0; i < 4; i++) step(1'b0, 1'b0, pat(91, i), ~(^pat(91, i)), 1'b0);

      // R3: first cell, ready only after byte 53; R2 gaps inside
      phase = "R3 cell0";
      for (int i = 0; i < NB; i++) begin
         wr(0, i, 1'b0, 1'b0);
         if (i == 20) step(1'b1, 1'b0, 8'hAA, 1'b1, 1'b0);
      end

      // R8: partial cell abandoned by a new start marker
      phase = "R8 restart";
      for (int i = 0; i < 20; i++) wr(7, i, 1'b0, 1'b0);
      for (int i = 0; i < NB; i++) wr(1, i, 1'b0, 1'b0);

      // R5/R6: store full, further cell is discarded
      phase = "R5 full";
      for (int i = 0; i < NB; i++) wr(9, i, 1'b0, 1'b0);

      // R4: drain the first cell
      phase = "R4 drain0";
      for (int i = 0; i < NB; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1);

      // R11: write cell2 in lockstep with reading cell1; R10 fault at byte 10
      phase = "R11 overlap";
      for (int i = 0; i < NB; i++) wr(2, i, 1'(i == 10), 1'b1);

      // R4: drain the last cell
      phase = "R4 drain2";
      for (int i = 0; i < NB; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
      phase = "R4 idle";
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1);
   endtask

   initial begin
      flow_mode = 1'b0;
      run_mode(1'b0);
      run_mode(1'b1);
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog [%s]: actual timeout expected completion", phase);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule